// File: doc/BRIEF.md
# Runahead Speculative Store Cache

This block is a small set-associative store cache used only while a core is pre-executing instructions speculatively past a long-latency miss. A store that pseudo-retires in that mode places its bytes in the cache together with a poison flag, which says whether the stored value depended on a missing load. A later speculative load to the same 8-byte line looks the line up. On a hit it gets the merged bytes and a poison flag. On a miss it gets a clear hit indication, and the core then reads from the normal memory path.

Results from this cache are allowed to be wrong. The cache is therefore kept small: 512 bytes with the default parameters, arranged as 16 sets of 4 ways of 8-byte lines. When a line has to be replaced, its data is dropped without any notice. Whenever the speculative-mode input is low, every line is invalidated, so each speculative episode starts with an empty cache.

The core drives one store port and one load port in each cycle. Each access names a byte address and a byte-enable mask over the addressed line. The load result appears one clock after the request.

Top module: `rsc_store_cache`

## Requirements
- R1: After reset, and in any cycle in which `ra_active` is low, a load returns `ld_hit`=0, `ld_data`=0 and `ld_poison`=0. A store presented while `ra_active` is low leaves no trace: a later load to that line in speculative mode misses.
- R2: A store to a line, followed by a load of that line, gives `ld_hit`=1 one clock after the load request. `ld_data` carries the stored bytes where the load's `ld_be` bit is set and zero in every other byte. Byte i of a line sits in bits [8i+7:8i].
- R3: Each byte enabled by a store takes that store's `st_poison` value. `ld_poison` is 1 exactly when at least one byte enabled in `ld_be` holds a set poison flag.
- R4: A store to a line that is already resident changes only the bytes enabled in `st_be`, both data and poison. All other bytes of the line keep their earlier data and poison.
- R5: When a store allocates a new line, the bytes that store does not enable get data 0 and a set poison flag.
- R6: One cycle with `ra_active` low invalidates every line. After `ra_active` rises again, loads to lines stored earlier miss.
- R7: A load that misses returns `ld_hit`=0, `ld_data`=0 and `ld_poison`=0. A cycle without `ld_en` also returns all zeros in the next cycle.
- R8: A store and a load to the same line in the same cycle return the line as updated by that store.
- R9: Each set holds up to 4 lines (NUM_WAYS). Allocating into a full set silently evicts the least recently used line of that set. A line counts as used when it is stored to or when a load hits it.
- R10: A store with `st_be`=0 has no effect on contents or on replacement order.
- R11: Address bits [2:0] are ignored. Bits [2+log2(NUM_SETS):3] select the set, and the bits above form the tag. Lines that differ only in tag do not alias.
- R12: If a store updates a set in a cycle, a load hit in that same set in that cycle does not change the replacement order. The store's line becomes the most recently used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ra_active | input | 1 | High while the core runs in speculative pre-execution mode; low flushes the cache |
| st_en | input | 1 | Pseudo-retired store present |
| st_addr | input | ADDR_W | Store byte address |
| st_data | input | 64 | Store data, byte i in bits [8i+7:8i] |
| st_be | input | 8 | Store byte enables |
| st_poison | input | 1 | Store value depends on a missing load |
| ld_en | input | 1 | Speculative load lookup request |
| ld_addr | input | ADDR_W | Load byte address |
| ld_be | input | 8 | Load byte enables |
| ld_hit | output | 1 | Line found (one cycle after request) |
| ld_data | output | 64 | Line data masked by the load's byte enables |
| ld_poison | output | 1 | At least one requested byte is poisoned |

## Verification
The bench builds the cache with 4 sets, 4 ways and a 12-bit address. With only 4 sets, a short pool of line addresses fills sets quickly, so a few hundred random cycles reach eviction, re-allocation into a set just flushed, and same-set store/load collisions. Directed sequences pin down the LRU victim choice, including the case where a store and a load hit the same set in one cycle. They also cover poisoning on partial allocation, flush on mode exit, and the same-cycle forwarding of store data to a load.

// File: rtl/rsc_pkg.sv
`timescale 1ns/1ps
package rsc_pkg;
  localparam int LINE_BYTES = 8;
  localparam int LINE_BITS  = LINE_BYTES * 8;
  localparam int OFF_W      = $clog2(LINE_BYTES);

  typedef logic [LINE_BITS-1:0]  line_t;
  typedef logic [LINE_BYTES-1:0] lmask_t;

  // expand a byte-enable vector into a bit mask
  function automatic line_t byte_mask(lmask_t be);
    line_t m;
    for (int i = 0; i < LINE_BYTES; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction

  // overlay the enabled bytes of nw onto old
  function automatic line_t merge_line(line_t old, line_t nw, lmask_t be);
    return (old & ~byte_mask(be)) | (nw & byte_mask(be));
  endfunction

  // enabled bytes take the store's poison flag, others keep theirs
  function automatic lmask_t merge_poison(lmask_t old, lmask_t be, logic p);
    return (old & ~be) | (be & {LINE_BYTES{p}});
  endfunction

  function automatic logic any_poison(lmask_t pois, lmask_t be);
    return |(pois & be);
  endfunction
endpackage

// File: rtl/rsc_way_match.sv
`timescale 1ns/1ps
module rsc_way_match #(
  parameter int NUM_WAYS = 4,
  parameter int TAG_W    = 8,
  localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_WAYS-1:0]       way_valid,
  input  logic [NUM_WAYS*TAG_W-1:0] way_tags,
  input  logic [TAG_W-1:0]          probe_tag,
  output logic                      hit,
  output logic [WAY_W-1:0]          hit_way
);
  logic [NUM_WAYS-1:0] match;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
    assign match[w] = way_valid[w] && (way_tags[w*TAG_W +: TAG_W] == probe_tag);
  end

  always_comb begin
    hit_way = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (match[w]) hit_way = WAY_W'(w);
    end
  end

  assign hit = |match;

  // a line is never resident in two ways of one set
  AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(match)); // R4
endmodule

// File: rtl/rsc_lru_set.sv
`timescale 1ns/1ps
module rsc_lru_set #(
  parameter int NUM_WAYS = 4,
  localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             touch_en,
  input  logic [WAY_W-1:0] touch_way,
  output logic [WAY_W-1:0] oldest_way
);
  // age 0 = most recent, NUM_WAYS-1 = least recent; ages stay a permutation
  logic [WAY_W-1:0] age [NUM_WAYS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < NUM_WAYS; w++) age[w] <= WAY_W'(w);
    end else if (clr) begin
      for (int w = 0; w < NUM_WAYS; w++) age[w] <= WAY_W'(w);
    end else if (touch_en) begin
      for (int w = 0; w < NUM_WAYS; w++) begin
        if (WAY_W'(w) == touch_way)        age[w] <= '0;
        else if (age[w] < age[touch_way])  age[w] <= age[w] + 1'b1;
      end
    end
  end

  always_comb begin
    oldest_way = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (age[w] == WAY_W'(NUM_WAYS - 1)) oldest_way = WAY_W'(w);
    end
  end

  if (NUM_WAYS > 1) begin : g_chk
    // a way just touched is never the next victim
    AST_TOUCH_NOT_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
      (touch_en && !clr) |=> (oldest_way != $past(touch_way))); // R9
  end
endmodule

// File: rtl/rsc_store_cache.sv
`timescale 1ns/1ps
module rsc_store_cache
  import rsc_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int NUM_SETS = 16,
  parameter int NUM_WAYS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ra_active,
  input  logic                  st_en,
  input  logic [ADDR_W-1:0]     st_addr,
  input  logic [LINE_BITS-1:0]  st_data,
  input  logic [LINE_BYTES-1:0] st_be,
  input  logic                  st_poison,
  input  logic                  ld_en,
  input  logic [ADDR_W-1:0]     ld_addr,
  input  logic [LINE_BYTES-1:0] ld_be,
  output logic                  ld_hit,
  output logic [LINE_BITS-1:0]  ld_data,
  output logic                  ld_poison
);
  localparam int IDX_W = $clog2(NUM_SETS);
  localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1;
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int LA_W  = ADDR_W - OFF_W;

  // ---------------- storage ----------------
  logic [NUM_WAYS-1:0] vld_q [NUM_SETS];
  logic [TAG_W-1:0]    tag_q [NUM_SETS][NUM_WAYS];
  line_t               dat_q [NUM_SETS][NUM_WAYS];
  lmask_t              psn_q [NUM_SETS][NUM_WAYS];

  // ---------------- address decode ----------------
  logic [IDX_W-1:0] st_set, ld_set;
  logic [TAG_W-1:0] st_tag, ld_tag;
  logic             unused_offset_bits;

  assign st_set = st_addr[OFF_W +: IDX_W];
  assign ld_set = ld_addr[OFF_W +: IDX_W];
  assign st_tag = st_addr[ADDR_W-1 -: TAG_W];
  assign ld_tag = ld_addr[ADDR_W-1 -: TAG_W];
  assign unused_offset_bits = ^{st_addr[OFF_W-1:0], ld_addr[OFF_W-1:0]};

  // ---------------- tag lookup, one per port ----------------
  logic [NUM_WAYS*TAG_W-1:0] st_tags_flat, ld_tags_flat;
  logic                      st_hit, ld_hit_raw;
  logic [WAY_W-1:0]          st_hit_way, ld_hit_way;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_flat
    assign st_tags_flat[w*TAG_W +: TAG_W] = tag_q[st_set][w];
    assign ld_tags_flat[w*TAG_W +: TAG_W] = tag_q[ld_set][w];
  end

  rsc_way_match #(.NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W)) i_st_match (
    .clk(clk), .rst_n(rst_n), .way_valid(vld_q[st_set]), .way_tags(st_tags_flat),
    .probe_tag(st_tag), .hit(st_hit), .hit_way(st_hit_way)
  );

  rsc_way_match #(.NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W)) i_ld_match (
    .clk(clk), .rst_n(rst_n), .way_valid(vld_q[ld_set]), .way_tags(ld_tags_flat),
    .probe_tag(ld_tag), .hit(ld_hit_raw), .hit_way(ld_hit_way)
  );

  // ---------------- named events ----------------
  logic flush;       // mode inactive: wipe everything
  logic st_do;       // effective store this cycle
  logic st_alloc;    // store allocates a new line
  logic ld_live;     // load lookup in speculative mode
  logic same_line;   // store and load hit the same line
  logic ld_evicted;  // store evicts the line the load found
  logic ld_found;    // load result is a hit
  logic ld_touch;    // load hit updates replacement order

  assign flush     = !ra_active;
  assign st_do     = ra_active && st_en && (|st_be);
  assign st_alloc  = st_do && !st_hit;
  assign ld_live   = ra_active && ld_en;
  assign same_line = st_do && (st_addr[ADDR_W-1:OFF_W] == ld_addr[ADDR_W-1:OFF_W]);

  // ---------------- victim choice ----------------
  logic [WAY_W-1:0] oldest_w [NUM_SETS];
  logic [WAY_W-1:0] victim_way;
  logic             free_found;

  always_comb begin
    victim_way = oldest_w[st_set];
    free_found = 1'b0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (!free_found && !vld_q[st_set][w]) begin
        victim_way = WAY_W'(w);
        free_found = 1'b1;
      end
    end
  end

  logic [WAY_W-1:0] st_way;
  assign st_way = st_hit ? st_hit_way : victim_way;

  // ---------------- store merge ----------------
  line_t  st_old_dat, st_new_dat;
  lmask_t st_old_psn, st_new_psn;

  assign st_old_dat = st_hit ? dat_q[st_set][st_hit_way] : '0;
  assign st_old_psn = st_hit ? psn_q[st_set][st_hit_way] : '1;
  assign st_new_dat = merge_line(st_old_dat, st_data, st_be);
  assign st_new_psn = merge_poison(st_old_psn, st_be, st_poison);

  // ---------------- load resolution ----------------
  line_t  ld_line;
  lmask_t ld_line_psn;

  assign ld_evicted = st_alloc && (st_set == ld_set) && (st_way == ld_hit_way);
  assign ld_found   = ld_live && (same_line || (ld_hit_raw && !ld_evicted));
  assign ld_touch   = ld_live && ld_hit_raw && !(st_do && (st_set == ld_set));
  assign ld_line    = same_line ? st_new_dat : dat_q[ld_set][ld_hit_way];
  assign ld_line_psn = same_line ? st_new_psn : psn_q[ld_set][ld_hit_way];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_hit    <= 1'b0;
      ld_data   <= '0;
      ld_poison <= 1'b0;
    end else begin
      ld_hit    <= ld_found;
      ld_data   <= ld_found ? (ld_line & byte_mask(ld_be)) : '0;
      ld_poison <= ld_found && any_poison(ld_line_psn, ld_be);
    end
  end

  // ---------------- state update ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++) vld_q[s] <= '0;
    end else if (flush) begin
      for (int s = 0; s < NUM_SETS; s++) vld_q[s] <= '0;
    end else if (st_do) begin
      vld_q[st_set][st_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (st_do) begin
      tag_q[st_set][st_way] <= st_tag;
      dat_q[st_set][st_way] <= st_new_dat;
      psn_q[st_set][st_way] <= st_new_psn;
    end
  end

  // ---------------- replacement order, one tracker per set ----------------
  for (genvar s = 0; s < NUM_SETS; s++) begin : g_lru
    logic             st_here, ld_here, touch_en;
    logic [WAY_W-1:0] touch_way;

    assign st_here   = st_do && (st_set == IDX_W'(s));
    assign ld_here   = ld_touch && (ld_set == IDX_W'(s));
    assign touch_en  = st_here || ld_here;
    assign touch_way = st_here ? st_way : ld_hit_way;

    rsc_lru_set #(.NUM_WAYS(NUM_WAYS)) i_lru (
      .clk(clk), .rst_n(rst_n), .clr(flush), .touch_en(touch_en),
      .touch_way(touch_way), .oldest_way(oldest_w[s])
    );
  end

  // ---------------- assertions ----------------
  logic vld_any;
  always_comb begin
    vld_any = 1'b0;
    for (int s = 0; s < NUM_SETS; s++) vld_any = vld_any | (|vld_q[s]);
  end

  AST_IDLE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    !ra_active |=> !ld_hit); // R1

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !ra_active |=> !vld_any); // R6

  AST_NO_REQ_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_en |=> (!ld_hit && !ld_poison)); // R7

  AST_BYPASS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_active && st_en && (|st_be) && ld_en &&
     (st_addr[ADDR_W-1:OFF_W] == ld_addr[ADDR_W-1:OFF_W])) |=> ld_hit); // R8

  AST_ALLOC_POISON: assert property (@(posedge clk) disable iff (!rst_n)
    (st_alloc && ld_en && same_line && ((~st_be & ld_be) != '0)) |=> ld_poison); // R5

  AST_STORE_RESIDENT: assert property (@(posedge clk) disable iff (!rst_n)
    st_do |=> vld_any); // R2

  logic [LA_W-1:0] unused_la;
  assign unused_la = '0;
endmodule

// File: tb/test_rsc_store_cache.sv
`timescale 1ns/1ps
module test_rsc_store_cache;
  localparam int SETS = 4;
  localparam int WAYS = 4;
  localparam int AW   = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ra_active = 1'b0;
  logic        st_en = 1'b0;
  logic [AW-1:0] st_addr = '0;
  logic [63:0] st_data = '0;
  logic [7:0]  st_be = '0;
  logic        st_poison = 1'b0;
  logic        ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [7:0]  ld_be = '0;
  logic        ld_hit;
  logic [63:0] ld_data;
  logic        ld_poison;

  always #10 clk = ~clk;

  rsc_store_cache #(.ADDR_W(AW), .NUM_SETS(SETS), .NUM_WAYS(WAYS)) i_rsc_store_cache (
    .clk(clk), .rst_n(rst_n), .ra_active(ra_active),
    .st_en(st_en), .st_addr(st_addr), .st_data(st_data), .st_be(st_be), .st_poison(st_poison),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_be(ld_be),
    .ld_hit(ld_hit), .ld_data(ld_data), .ld_poison(ld_poison)
  );

  int checks = 0;
  int fails  = 0;

  // ---- reference model: per-set recency lists of line numbers, MRU first ----
  logic [63:0] mdat [int];
  logic [7:0]  mpsn [int];
  int          lq [SETS][$];
  logic        e_hit = 1'b0;
  logic [63:0] e_data = '0;
  logic        e_psn = 1'b0;

  function automatic int find_line(int s, int line);
    for (int i = 0; i < lq[s].size(); i++) if (lq[s][i] == line) return i;
    return -1;
  endfunction

  function automatic logic [63:0] expand(logic [7:0] be);
    logic [63:0] m;
    for (int i = 0; i < 8; i++) m[i*8 +: 8] = be[i] ? 8'hFF : 8'h00;
    return m;
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // compare last result, drive one cycle, update model, advance to next negedge
  task automatic step(string tag, bit act, bit se, logic [AW-1:0] sa, logic [63:0] sd,
                      logic [7:0] sb, bit sp, bit le, logic [AW-1:0] la, logic [7:0] lb);
    int wset;
    checks++;
    if (ld_hit !== e_hit || ld_data !== e_data || ld_poison !== e_psn) begin
      fails++;
      $display("FAIL %s: actual hit=%0b data=%h poison=%0b expected hit=%0b data=%h poison=%0b",
               tag, ld_hit, ld_data, ld_poison, e_hit, e_data, e_psn);
    end
    ra_active = act; st_en = se; st_addr = sa; st_data = sd; st_be = sb; st_poison = sp;
    ld_en = le; ld_addr = la; ld_be = lb;
    e_hit = 1'b0; e_data = '0; e_psn = 1'b0;
    if (!act) begin
      for (int s = 0; s < SETS; s++) lq[s].delete();
      mdat.delete(); mpsn.delete();
    end else begin
      wset = -1;
      if (se && sb != 8'h00) begin
        int line = int'(sa >> 3);
        int s = line % SETS;
        int idx = find_line(s, line);
        wset = s;
        if (idx >= 0) begin
          lq[s].delete(idx);
          for (int b = 0; b < 8; b++) if (sb[b]) begin
            mdat[line][b*8 +: 8] = sd[b*8 +: 8];
            mpsn[line][b] = sp;
          end
        end else begin
          if (lq[s].size() == WAYS) begin
            int ev = lq[s].pop_back();
            mdat.delete(ev); mpsn.delete(ev);
          end
          mdat[line] = sd & expand(sb);
          for (int b = 0; b < 8; b++) mpsn[line][b] = sb[b] ? sp : 1'b1;
        end
        lq[s].push_front(line);
      end
      if (le) begin
        int line = int'(la >> 3);
        int s = line % SETS;
        int idx = find_line(s, line);
        if (idx >= 0) begin
          e_hit = 1'b1;
          e_data = mdat[line] & expand(lb);
          e_psn = |(mpsn[line] & lb);
          if (wset != s) begin
            lq[s].delete(idx);
            lq[s].push_front(line);
          end
        end
      end
    end
    @(negedge clk);
  endtask

  task automatic st(string tag, logic [AW-1:0] a, logic [63:0] d, logic [7:0] b, bit p);
    step(tag, 1'b1, 1'b1, a, d, b, p, 1'b0, '0, '0);
  endtask

  task automatic ld(string tag, logic [AW-1:0] a, logic [7:0] b);
    step(tag, 1'b1, 1'b0, '0, '0, '0, 1'b0, 1'b1, a, b);
  endtask

  // directed check of the hit flag against a hand-derived value
  task automatic probe(string tag, bit exp_hit);
    checks++;
    if (ld_hit !== exp_hit) begin
      fails++;
      $display("FAIL %s: actual hit=%0b expected hit=%0b", tag, ld_hit, exp_hit);
    end
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    summary();
    $finish;
  end

  localparam logic [AW-1:0] A_ADDR = 12'd64;   // line 8, set 0
  localparam logic [AW-1:0] B_ADDR = 12'd72;   // line 9, set 1
  localparam logic [AW-1:0] C_ADDR = 12'd80;   // line 10, set 2

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (ld_hit !== 1'b0 || ld_data !== 64'h0 || ld_poison !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: actual hit=%0b data=%h poison=%0b expected 0/0/0", ld_hit, ld_data, ld_poison);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R1: store while inactive is ignored
    step("R1 idle store", 1'b0, 1'b1, A_ADDR, 64'h1111_1111_1111_1111, 8'hFF, 1'b0, 1'b1, A_ADDR, 8'hFF);
    ld("R1 idle-store miss", A_ADDR, 8'hFF);
    probe("R1 idle-store miss", 1'b0);

    // R2 basic store/load
    st("R2 store", A_ADDR, 64'h0123_4567_89AB_CDEF, 8'hFF, 1'b0);
    ld("R2 load", A_ADDR, 8'hFF);
    probe("R2 hit", 1'b1);
    ld("R2 masked load", A_ADDR, 8'h3C);

    // R3/R4 partial poisoned store
    st("R4 partial store", A_ADDR, 64'hFFFF_FFFF_FFFF_FFFF, 8'h0F, 1'b1);
    ld("R3 clean upper bytes", A_ADDR, 8'hF0);
    ld("R3 poisoned byte0", A_ADDR, 8'h01);
    ld("R4 merged line", A_ADDR, 8'hFF);

    // R5 allocation poisons unwritten bytes
    st("R5 alloc", B_ADDR, 64'h0000_0000_0000_BEEF, 8'h03, 1'b0);
    ld("R5 full read poisoned", B_ADDR, 8'hFF);
    ld("R5 written bytes clean", B_ADDR, 8'h03);

    // R10 empty byte enable
    st("R10 empty store", A_ADDR, 64'h0, 8'h00, 1'b0);
    ld("R10 unchanged", A_ADDR, 8'hFF);

    // R8 same-cycle store + load, new line
    step("R8 bypass", 1'b1, 1'b1, C_ADDR, 64'hCAFE_0000_0000_0042, 8'h81, 1'b0, 1'b1, C_ADDR, 8'hFF);
    probe("R8 bypass hit", 1'b1);

    // R7 miss on unknown line
    ld("R7 miss", 12'd88, 8'hFF);
    probe("R7 miss", 1'b0);

    // R9 LRU in set 3: lines 3,7,11,15,19,23
    st("R9 fill L0", 12'd24,  64'h10, 8'hFF, 1'b0);
    st("R9 fill L1", 12'd56,  64'h11, 8'hFF, 1'b0);
    st("R9 fill L2", 12'd88,  64'h12, 8'hFF, 1'b0);
    st("R9 fill L3", 12'd120, 64'h13, 8'hFF, 1'b0);
    ld("R9 touch L0", 12'd24, 8'hFF);
    st("R9 alloc L4", 12'd152, 64'h14, 8'hFF, 1'b0);
    ld("R9 L1 evicted", 12'd56, 8'hFF);
    probe("R9 L1 evicted", 1'b0);
    ld("R9 L0 kept", 12'd24, 8'hFF);
    probe("R9 L0 kept", 1'b1);

    // R12 same-set store and load hit: load does not refresh L3
    step("R12 store L2 load L3", 1'b1, 1'b1, 12'd88, 64'h22, 8'h01, 1'b0, 1'b1, 12'd120, 8'hFF);
    st("R12 alloc L5", 12'd184, 64'h15, 8'hFF, 1'b0);
    ld("R12 L3 evicted", 12'd120, 8'hFF);
    probe("R12 L3 evicted", 1'b0);
    ld("R12 L4 kept", 12'd152, 8'hFF);
    probe("R12 L4 kept", 1'b1);

    // R11 offset bits ignored, tag distinguishes lines
    st("R11 offset store", A_ADDR + 12'd5, 64'h5A00_0000_0000_0000, 8'h80, 1'b0);
    ld("R11 offset load", A_ADDR + 12'd2, 8'hFF);
    probe("R11 offset hit", 1'b1);
    ld("R11 other tag", 12'd96, 8'hFF);
    probe("R11 other tag miss", 1'b0);

    // R6 exit flush
    step("R6 exit", 1'b0, 1'b0, '0, '0, '0, 1'b0, 1'b0, '0, '0);
    ld("R6 after re-entry", A_ADDR, 8'hFF);
    probe("R6 flushed", 1'b0);
    ld("R6 other line", B_ADDR, 8'hFF);
    probe("R6 flushed B", 1'b0);

    // random traffic against the model
    for (int n = 0; n < 600; n++) begin
      bit act = ($urandom % 50) != 0;
      int sl = int'($urandom % SETS) + SETS * int'($urandom % 6);
      int ll = int'($urandom % SETS) + SETS * int'($urandom % 6);
      step("R2-R12 random", act, ($urandom % 2) == 0, AW'(sl * 8 + int'($urandom % 8)),
           {$urandom, $urandom}, 8'($urandom), ($urandom % 4) == 0,
           ($urandom % 3) != 0, AW'(ll * 8 + int'($urandom % 8)), 8'($urandom));
    end
    step("R7 final", 1'b1, 1'b0, '0, '0, '0, 1'b0, 1'b0, '0, '0);
    step("R7 final idle", 1'b1, 1'b0, '0, '0, '0, 1'b0, 1'b0, '0, '0);

    summary();
    $finish;
  end
endmodule